// File: doc/BRIEF.md
# Asynchronous Device Access Strobe Timer

This block times one access to a simple asynchronous device such as a flash, an SRAM or a board register. A one-clock start pulse begins the access. The block latches the access direction and the timing options of the selected bank at that start, then steps through up to three phases:

- a chip-select setup delay;
- an active window of programmable length, which ends with a one-clock transfer acknowledge;
- for reads only, an optional hold of idle clocks.

It drives the active-low chip-select, output-enable and write-enable strobes, and a busy flag. The busy flag tells the requester when the next access may start.

The active window normally ends when the internal wait counter expires. An external acknowledge input can end the window earlier. In external-only mode, the window ends only on that input. Further options can do the following:

- stretch the setup and wait counts;
- drop chip select and write enable one clock before the internal acknowledge;
- hold off the next access after a read.

Top module: `mem_cycle_timer`

## Requirements
- R1: After reset, and whenever busy is low, cs_n, oe_n and we_n are high and ack is low.
- R2: A start accepted at clock edge k begins the cycle. Cycles are numbered 1, 2, ... after edge k. For cycles 1..S, cs_n stays high and busy is high. S = setup_code × M, where M = 2 if relaxed = 1 and M = 1 otherwise. cs_n goes low in cycle S+1.
- R3: With no external acknowledge, the active window lasts A = 1 + wait_cnt × M cycles. ack is high for exactly one cycle, cycle S+A.
- R4: relaxed = 1 doubles both the setup delay and the wait-state count, as given by M in R2 and R3.
- R5: oe_n is low only during the active window of a read (is_read = 1). we_n is low only during the active window of a write. The two are never low together.
- R6: When early_neg = 1, ext_ack_only = 0 and wait_cnt ≠ 0, cs_n and we_n are high in the internal acknowledge cycle. oe_n is not affected.
- R7: With ext_ack_only = 0, ext_ack_in high in an active-window cycle before S+A makes ack high in that same cycle and ends the window. ext_ack_in outside the active window has no effect.
- R8: With ext_ack_only = 1, the internal count does not end the window. The window and ack end only in the cycle where ext_ack_in is high.
- R9: When ext_hold = 1 and the access is a read, busy stays high for M further cycles after the ack cycle, with all strobes high. Writes, and reads with ext_hold = 0, drop busy in the cycle after ack.
- R10: A start while busy is ignored. Direction and options are taken only from the inputs at the accepted start; input changes during the access do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an access (accepted only when idle) |
| is_read | input | 1 | 1 = read, 0 = write |
| wait_cnt | input | WAIT_W | Wait-state count |
| setup_code | input | SETUP_W | Chip-select setup delay code |
| relaxed | input | 1 | Double setup and wait counts |
| early_neg | input | 1 | Negate cs_n/we_n one clock before internal ack |
| ext_hold | input | 1 | Insert idle clocks after a read |
| ext_ack_only | input | 1 | Cycle ends only on external acknowledge |
| ext_ack_in | input | 1 | External acknowledge, active high |
| cs_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| ack | output | 1 | Transfer acknowledge, one clock |
| busy | output | 1 | Access in progress, including the read hold |

## Verification
The bench uses the default widths: a 4-bit wait count and a 2-bit setup code. At these widths, every combination of direction, setup code, wait count, relaxed timing, early negation and read hold can be swept exhaustively, 1024 accesses in all, with every output compared on every cycle. Those widths also keep the longest window at 31 clocks. That makes early external acknowledges at every position of a window, external-only terminations, and starts that arrive during setup, the active window and the hold all cheap to cover.

// File: rtl/mct_pkg.sv
// Shared types for the memory cycle timer.
// Assumes: a single access at a time; phases advance in a fixed order.
package mct_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_t;

endpackage

// File: rtl/mct_len_calc.sv
// Converts the bank option fields into phase lengths in clocks.
// Assumes: CNT_W is wide enough for a doubled wait count plus one.
module mct_len_calc #(
    parameter int WAIT_W  = 4,
    parameter int SETUP_W = 2,
    parameter int CNT_W   = 6
) (
    input  logic [WAIT_W-1:0]  wait_cnt,
    input  logic [SETUP_W-1:0] setup_code,
    input  logic               relaxed,
    input  logic               is_read,
    input  logic               ext_hold,
    output logic [CNT_W-1:0]   setup_len,
    output logic [CNT_W-1:0]   act_len,
    output logic [CNT_W-1:0]   hold_len
);

    logic [CNT_W-1:0] su_base;
    logic [CNT_W-1:0] wt_base;

    // Widen the raw fields to counter width.
    always_comb begin
        su_base = CNT_W'(setup_code);
        wt_base = CNT_W'(wait_cnt);
    end

    // Setup and active lengths, doubled under relaxed timing.
    always_comb begin
        setup_len = relaxed ? (su_base << 1) : su_base;
        act_len   = CNT_W'(1) + (relaxed ? (wt_base << 1) : wt_base);
    end

    // Read hold: one idle clock, or two when relaxed.
    always_comb begin
        if (is_read && ext_hold)
            hold_len = relaxed ? CNT_W'(2) : CNT_W'(1);
        else
            hold_len = '0;
    end

endmodule

// File: rtl/mct_seq.sv
// Phase sequencer: accepts start when idle, latches the access options,
// and counts setup, active and hold phases. Produces the acknowledge.
// Assumes: act_len >= 1; lengths are sampled only at an accepted start.
module mct_seq
    import mct_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_read,
    input  logic             early_neg,
    input  logic             ext_ack_only,
    input  logic             wait_nz,
    input  logic             ext_ack_in,
    input  logic [CNT_W-1:0] setup_len,
    input  logic [CNT_W-1:0] act_len,
    input  logic [CNT_W-1:0] hold_len,
    output phase_t           phase,
    output logic             cnt_zero,
    output logic             rd_q,
    output logic             early_q,
    output logic             eonly_q,
    output logic             wnz_q,
    output logic             ack
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] act_len_q;
    logic [CNT_W-1:0] hold_len_q;

    // Counter reached its last clock of the current phase.
    always_comb cnt_zero = (cnt == '0);

    // Acknowledge: external at any active clock, internal on the last one.
    always_comb ack = (phase == PH_ACTIVE) && (ext_ack_in || (cnt_zero && !eonly_q));

    // Latch the access options at an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q       <= 1'b0;
            early_q    <= 1'b0;
            eonly_q    <= 1'b0;
            wnz_q      <= 1'b0;
            act_len_q  <= '0;
            hold_len_q <= '0;
        end else if (phase == PH_IDLE && start) begin
            rd_q       <= is_read;
            early_q    <= early_neg;
            eonly_q    <= ext_ack_only;
            wnz_q      <= wait_nz;
            act_len_q  <= act_len;
            hold_len_q <= hold_len;
        end
    end

    // Phase transitions and down-counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        if (setup_len != '0) begin
                            phase <= PH_SETUP;
                            cnt   <= setup_len - CNT_W'(1);
                        end else begin
                            phase <= PH_ACTIVE;
                            cnt   <= act_len - CNT_W'(1);
                        end
                    end
                end
                PH_SETUP: begin
                    if (cnt_zero) begin
                        phase <= PH_ACTIVE;
                        cnt   <= act_len_q - CNT_W'(1);
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                PH_ACTIVE: begin
                    if (ack) begin
                        if (hold_len_q != '0) begin
                            phase <= PH_HOLD;
                            cnt   <= hold_len_q - CNT_W'(1);
                        end else begin
                            phase <= PH_IDLE;
                            cnt   <= '0;
                        end
                    end else if (!cnt_zero) begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                PH_HOLD: begin
                    if (cnt_zero) phase <= PH_IDLE;
                    else          cnt   <= cnt - CNT_W'(1);
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R3: acknowledge never lasts two clocks.
    p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R9: no acknowledge during the read hold.
    p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD) |-> !ack);

    // R2: setup always leads into setup or the active window.
    p_setup_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SETUP) |=> (phase == PH_SETUP || phase == PH_ACTIVE));

    // R10: a start while busy leaves the latched direction unchanged.
    p_busy_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> $stable(rd_q));

endmodule

// File: rtl/mct_strobe.sv
// Decodes sequencer state into the active-low device strobes and busy.
// Assumes: phase and option latches come from mct_seq.
module mct_strobe
    import mct_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_t phase,
    input  logic   cnt_zero,
    input  logic   rd_q,
    input  logic   early_q,
    input  logic   eonly_q,
    input  logic   wnz_q,
    output logic   cs_n,
    output logic   oe_n,
    output logic   we_n,
    output logic   busy
);

    logic active;
    logic early_cut;

    // Active window and the early-negation clock inside it.
    always_comb begin
        active    = (phase == PH_ACTIVE);
        early_cut = active && cnt_zero && early_q && !eonly_q && wnz_q;
    end

    // Strobe decode; output enable ignores early negation.
    always_comb begin
        cs_n = !(active && !early_cut);
        we_n = !(active && !rd_q && !early_cut);
        oe_n = !(active && rd_q);
        busy = (phase != PH_IDLE);
    end

    // R5: output enable and write enable never overlap.
    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));

    // R1: strobes quiet whenever idle.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && oe_n && we_n));

endmodule

// File: rtl/mem_cycle_timer.sv
// Top: single-access strobe timer for an asynchronous device.
// Assumes: start is a pulse; options are valid in the start cycle.
module mem_cycle_timer
    import mct_pkg::*;
#(
    parameter int WAIT_W  = 4,
    parameter int SETUP_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               is_read,
    input  logic [WAIT_W-1:0]  wait_cnt,
    input  logic [SETUP_W-1:0] setup_code,
    input  logic               relaxed,
    input  logic               early_neg,
    input  logic               ext_hold,
    input  logic               ext_ack_only,
    input  logic               ext_ack_in,
    output logic               cs_n,
    output logic               oe_n,
    output logic               we_n,
    output logic               ack,
    output logic               busy
);

    localparam int CNT_W = ((WAIT_W > SETUP_W) ? WAIT_W : SETUP_W) + 2;

    logic [CNT_W-1:0] setup_len;
    logic [CNT_W-1:0] act_len;
    logic [CNT_W-1:0] hold_len;
    phase_t           phase;
    logic             cnt_zero;
    logic             rd_q;
    logic             early_q;
    logic             eonly_q;
    logic             wnz_q;
    logic             wait_nz;

    // Nonzero wait count enables early negation.
    always_comb wait_nz = (wait_cnt != '0);

    mct_len_calc #(.WAIT_W(WAIT_W), .SETUP_W(SETUP_W), .CNT_W(CNT_W)) u_len (
        .wait_cnt  (wait_cnt),
        .setup_code(setup_code),
        .relaxed   (relaxed),
        .is_read   (is_read),
        .ext_hold  (ext_hold),
        .setup_len (setup_len),
        .act_len   (act_len),
        .hold_len  (hold_len)
    );

    mct_seq #(.CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .is_read     (is_read),
        .early_neg   (early_neg),
        .ext_ack_only(ext_ack_only),
        .wait_nz     (wait_nz),
        .ext_ack_in  (ext_ack_in),
        .setup_len   (setup_len),
        .act_len     (act_len),
        .hold_len    (hold_len),
        .phase       (phase),
        .cnt_zero    (cnt_zero),
        .rd_q        (rd_q),
        .early_q     (early_q),
        .eonly_q     (eonly_q),
        .wnz_q       (wnz_q),
        .ack         (ack)
    );

    mct_strobe u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase   (phase),
        .cnt_zero(cnt_zero),
        .rd_q    (rd_q),
        .early_q (early_q),
        .eonly_q (eonly_q),
        .wnz_q   (wnz_q),
        .cs_n    (cs_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .busy    (busy)
    );

    // R11-style guard for R3: acknowledge only while busy.
    p_ack_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> busy);

    // R9: busy falls only after an ack or from the hold phase.
    p_busy_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ack && phase != PH_HOLD) |=> busy);

endmodule

// File: tb/tb_mem_cycle_timer.sv
// Self-checking bench: exhaustive option sweep plus external-ack and
// busy-start cases, with a per-cycle arithmetic model.
module tb_mem_cycle_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       is_read = 1'b0;
    logic [3:0] wait_cnt = '0;
    logic [1:0] setup_code = '0;
    logic       relaxed = 1'b0;
    logic       early_neg = 1'b0;
    logic       ext_hold = 1'b0;
    logic       ext_ack_only = 1'b0;
    logic       ext_ack_in = 1'b0;
    logic       cs_n, oe_n, we_n, ack, busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    mem_cycle_timer #(.WAIT_W(4), .SETUP_W(2)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_read(is_read),
        .wait_cnt(wait_cnt), .setup_code(setup_code), .relaxed(relaxed),
        .early_neg(early_neg), .ext_hold(ext_hold), .ext_ack_only(ext_ack_only),
        .ext_ack_in(ext_ack_in), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
        .ack(ack), .busy(busy)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual cycle %0d expected < 190000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check_bit(input string tag, input logic act, input logic exp_v, input int j);
        checks = checks + 1;
        if (act !== exp_v) begin
            errors = errors + 1;
            $display("FAIL %s cycle %0d: actual %b expected %b", tag, j, act, exp_v);
        end
    endtask

    // One access with a per-cycle model. xat = cycle of external ack (0 = none).
    task automatic run_access(input logic rd, input int sc, input int w, input logic rlx,
                              input logic en, input logic hold, input logic xen,
                              input int xat, input logic poke);
        int m, s, a, h, fin, jmax;
        logic act_w, early, e_cs, e_oe, e_we, e_ack, e_busy;
        m = rlx ? 2 : 1;
        s = sc * m;
        a = 1 + w * m;
        h = (rd && hold) ? m : 0;
        if (xen) fin = xat;
        else if (xat > s && xat < s + a) fin = xat;
        else fin = s + a;
        jmax = fin + h + 1;
        @(negedge clk);
        is_read = rd; wait_cnt = 4'(w); setup_code = 2'(sc); relaxed = rlx;
        early_neg = en; ext_hold = hold; ext_ack_only = xen; ext_ack_in = 1'b0;
        start = 1'b1;
        for (int j = 1; j <= jmax; j++) begin
            @(negedge clk);
            ext_ack_in = (j == xat);
            if (poke && j < jmax) begin
                // R10: start and option changes while busy must be ignored
                start = 1'b1; is_read = ~rd; wait_cnt = 4'(w) ^ 4'hF;
            end else begin
                start = 1'b0; is_read = rd; wait_cnt = 4'(w);
            end
            #1;
            act_w  = (j > s) && (j <= fin);
            early  = en && !xen && (w != 0) && (j == s + a) && act_w;
            e_cs   = !(act_w && !early);
            e_we   = !(act_w && !rd && !early);
            e_oe   = !(act_w && rd);
            e_ack  = (j == fin);
            e_busy = (j <= fin + h);
            check_bit(early ? "R6 cs_n" : "R2 cs_n", cs_n, e_cs, j);
            check_bit(early ? "R6 we_n" : "R5 we_n", we_n, e_we, j);
            check_bit("R5 oe_n", oe_n, e_oe, j);
            check_bit(xat != 0 ? (xen ? "R8 ack" : "R7 ack") : "R3 ack", ack, e_ack, j);
            check_bit(poke ? "R10 busy" : "R9 busy", busy, e_busy, j);
        end
        ext_ack_in = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check_bit("R1 cs_n", cs_n, 1'b1, 0);
        check_bit("R1 oe_n", oe_n, 1'b1, 0);
        check_bit("R1 we_n", we_n, 1'b1, 0);
        check_bit("R1 ack", ack, 1'b0, 0);
        check_bit("R1 busy", busy, 1'b0, 0);

        // R2 R3 R4 R5 R6 R9: exhaustive option sweep
        for (int rd = 0; rd < 2; rd++)
            for (int sc = 0; sc < 4; sc++)
                for (int w = 0; w < 16; w++)
                    for (int rl = 0; rl < 2; rl++)
                        for (int en = 0; en < 2; en++)
                            for (int hd = 0; hd < 2; hd++)
                                run_access(rd[0], sc, w, rl[0], en[0], hd[0], 1'b0, 0, 1'b0);

        // R7: early external ack at every cycle, including during setup
        for (int x = 1; x <= 10; x++) begin
            run_access(1'b0, 2, 5, 1'b0, 1'b1, 1'b0, 1'b0, x, 1'b0);
            run_access(1'b1, 1, 3, 1'b1, 1'b0, 1'b1, 1'b0, x, 1'b0);
        end

        // R8: external-only termination beyond the internal count
        for (int x = 2; x <= 40; x += 3) begin
            run_access(1'b1, 1, 2, 1'b0, 1'b1, 1'b1, 1'b1, x, 1'b0);
            run_access(1'b0, 1, 0, 1'b0, 1'b1, 1'b0, 1'b1, x, 1'b0);
        end

        // R10: start and option changes while busy
        run_access(1'b1, 3, 4, 1'b1, 1'b0, 1'b1, 1'b0, 0, 1'b1);
        run_access(1'b0, 0, 7, 1'b0, 1'b1, 1'b0, 1'b0, 0, 1'b1);
        run_access(1'b1, 2, 0, 1'b0, 1'b0, 1'b1, 1'b1, 6, 1'b1);

        @(negedge clk);
        #1;
        check_bit("R1 idle busy", busy, 1'b0, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule